// File: doc/BRIEF.md
# Periodic Clock Error Trimmer

This block sits between the 32.768 kHz counting clock and the calendar of a real-time clock. It divides the counting-clock ticks down to a one-second strobe. Once per adjustment interval it nudges that division so that a slow or fast oscillator is corrected on average. The correction is a programmed number of counting-clock cycles, from 1 to 63. It is either added, which makes the corrected second shorter, or removed, which makes it longer. The interval is 10 seconds or 60 seconds, and a control bit picks between them.

Software programs an 8-bit trim register and two control bits through a single-cycle write port, and can read all three back. The trim register holds a cycle count and a direction code. The control bits are an automatic-adjust enable and the interval select. The interval select may only change while the direction code is zero, so the cadence can never switch underneath a pending correction. The state machine inside the divider has two named states. RUN counts ticks. HOLD freezes the divider for the programmed number of ticks when cycles are removed. The transition RUN->HOLD is taken on a subtracting boundary. The transition HOLD->RUN is taken on the last held tick.

Top module: `clk_err_trimmer`

## Requirements
- R1: After reset the trim register reads 0 (no adjustment), the interval select reads 0 (60-second cadence), the enable reads 0, and no second strobe is pending.
- R2: With no correction in effect, each second lasts exactly PRESC_DIV counting-clock ticks. Cycles in which `osc_tick` is low do not advance the divider.
- R3: A write with `wr_sel`=0 loads bits 5:0 as the cycle count N and bits 7:6 as the direction. Direction code 1 adds cycles, so the second that starts at an enabled interval boundary lasts PRESC_DIV-N ticks.
- R4: Direction code 2 removes cycles, so the second that starts at an enabled interval boundary lasts PRESC_DIV+N ticks. During this time the divider stays in HOLD and does not change.
- R5: The boundary falls on every 10th second when the interval select is 1, and on every 60th second when it is 0 (SHORT_SECS and LONG_SECS). A correction is applied exactly once per interval. All other seconds are nominal.
- R6: A write with `wr_sel`=1 loads bit 4 as the enable. While the enable is 0, no boundary alters a second.
- R7: A write with `wr_sel`=1 loads bit 5 as the interval select only when the stored direction is 0. Otherwise the select keeps its old value and only the enable is updated.
- R8: Direction code 3 is treated as no adjustment.
- R9: The trim register reads back on `trim_reg_o` as the byte last written with `wr_sel`=0.
- R10: `sec_pulse_o` is a single-cycle strobe that rises one clock after the edge on which the divider wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per counting-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the trim register, 1 selects the control bits |
| wr_data | input | CNT_W+2 | Write data |
| trim_reg_o | output | CNT_W+2 | Trim register readback {direction, count} |
| short_mode_o | output | 1 | Interval select readback (1 = short cadence) |
| auto_en_o | output | 1 | Automatic-adjust enable readback |
| sec_pulse_o | output | 1 | One-second strobe to the calendar |

## Verification
The bench measures the length of every second in ticks and compares it with a model of the interval counter kept in the bench. It sweeps every count from 0 to 63 in both directions. At N=63 an adding design that reloads the divider wrongly gives a second that is off by one, and a subtracting design that holds one tick too many or too few is caught in the same way. Disabled and reserved-direction boundaries are checked to stay nominal. A design that ignores the ordering rule would switch cadence while a correction is pending, which shows up both in the select readback and in where the next corrected second falls. Throttled ticks catch a divider that counts system clocks instead of ticks.

// File: rtl/cet_pkg.sv
package cet_pkg;
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_ADD  = 2'd1,
        DIR_SUB  = 2'd2,
        DIR_RSVD = 2'd3
    } trim_dir_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } presc_state_e;
endpackage

// File: rtl/cet_regs.sv
module cet_regs #(
    parameter int CNT_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_sel,
    input  logic [CNT_W+1:0]       wr_data,
    output logic [CNT_W-1:0]       cnt_o,
    output cet_pkg::trim_dir_e     dir_o,
    output logic                   short_o,
    output logic                   en_o
);
    import cet_pkg::*;

    localparam int DIR_LSB = CNT_W;
    localparam int EN_BIT  = 4;
    localparam int SEL_BIT = 5;

    logic [CNT_W-1:0] cnt_q;
    trim_dir_e        dir_q;
    logic             short_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            dir_q   <= DIR_NONE;
            short_q <= 1'b0;
            en_q    <= 1'b0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                cnt_q <= wr_data[CNT_W-1:0];
                dir_q <= trim_dir_e'(wr_data[DIR_LSB+1:DIR_LSB]);
            end else begin
                en_q <= wr_data[EN_BIT];
                if (dir_q == DIR_NONE)
                    short_q <= wr_data[SEL_BIT];
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign dir_o   = dir_q;
    assign short_o = short_q;
    assign en_o    = en_q;

    // R7
    sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && dir_q != DIR_NONE) |=> $stable(short_q));
endmodule

// File: rtl/cet_interval.sv
module cet_interval #(
    parameter int SHORT_SECS = 10,
    parameter int LONG_SECS  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic short_i,
    output logic boundary_o
);
    localparam int MAX_SECS = (LONG_SECS > SHORT_SECS) ? LONG_SECS : SHORT_SECS;
    localparam int SEC_W    = $clog2(MAX_SECS + 1);
    localparam logic [SEC_W-1:0] SHORT_LAST = SEC_W'(SHORT_SECS - 1);
    localparam logic [SEC_W-1:0] LONG_LAST  = SEC_W'(LONG_SECS - 1);
    localparam logic [SEC_W-1:0] MAX_LAST   = SEC_W'(MAX_SECS - 1);

    logic [SEC_W-1:0] sec_q;
    logic [SEC_W-1:0] last_sec;

    always_comb begin
        last_sec   = short_i ? SHORT_LAST : LONG_LAST;
        boundary_o = (sec_q >= last_sec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_q <= '0;
        else if (wrap_i)
            sec_q <= boundary_o ? '0 : sec_q + 1'b1;
    end

    // R5
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q <= MAX_LAST);

    // R5
    sec_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && boundary_o) |=> sec_q == '0);
endmodule

// File: rtl/cet_presc.sv
module cet_presc #(
    parameter int PRESC_DIV = 32768,
    parameter int CNT_W     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_tick_i,
    input  logic               boundary_i,
    input  logic               en_i,
    input  cet_pkg::trim_dir_e dir_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic               wrap_o,
    output logic               sec_pulse_o
);
    import cet_pkg::*;

    localparam int PW = $clog2(PRESC_DIV);
    localparam logic [PW-1:0] PSC_LAST = PW'(PRESC_DIV - 1);

    presc_state_e     state_q, state_d;
    logic [PW-1:0]    psc_q;
    logic [CNT_W-1:0] hold_q;
    logic             pulse_q;
    logic             wrap, apply, do_add, do_sub;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (do_sub) state_d = ST_HOLD;
            ST_HOLD: if (osc_tick_i && hold_q == CNT_W'(1)) state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // output and strobe decode
    always_comb begin
        wrap   = (state_q == ST_RUN) && osc_tick_i && (psc_q == PSC_LAST);
        apply  = wrap && boundary_i && en_i;
        do_add = apply && (dir_i == DIR_ADD);
        do_sub = apply && (dir_i == DIR_SUB) && (cnt_i != '0);
        wrap_o      = wrap;
        sec_pulse_o = pulse_q;
    end

    // divider datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q   <= '0;
            hold_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wrap;
            if (wrap)
                psc_q <= do_add ? PW'(cnt_i) : '0;
            else if (state_q == ST_RUN && osc_tick_i)
                psc_q <= psc_q + 1'b1;
            if (do_sub)
                hold_q <= cnt_i;
            else if (state_q == ST_HOLD && osc_tick_i)
                hold_q <= hold_q - 1'b1;
        end
    end

    // R4
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(psc_q));

    // R4
    hold_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> hold_q != '0);

    // R2
    psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_q <= PSC_LAST);

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/clk_err_trimmer.sv
module clk_err_trimmer #(
    parameter int PRESC_DIV  = 32768,
    parameter int SHORT_SECS = 10,
    parameter int LONG_SECS  = 60,
    parameter int CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W+1:0] wr_data,
    output logic [CNT_W+1:0] trim_reg_o,
    output logic             short_mode_o,
    output logic             auto_en_o,
    output logic             sec_pulse_o
);
    import cet_pkg::*;

    logic [CNT_W-1:0] cnt;
    trim_dir_e        dir;
    logic             short_sel, en;
    logic             wrap, boundary;

    cet_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cnt_o(cnt), .dir_o(dir),
        .short_o(short_sel), .en_o(en)
    );

    cet_interval #(.SHORT_SECS(SHORT_SECS), .LONG_SECS(LONG_SECS)) u_intv (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .short_i(short_sel),
        .boundary_o(boundary)
    );

    cet_presc #(.PRESC_DIV(PRESC_DIV), .CNT_W(CNT_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick),
        .boundary_i(boundary), .en_i(en), .dir_i(dir), .cnt_i(cnt),
        .wrap_o(wrap), .sec_pulse_o(sec_pulse_o)
    );

    assign trim_reg_o   = {dir, cnt};
    assign short_mode_o = short_sel;
    assign auto_en_o    = en;

    // R10
    pulse_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> sec_pulse_o);
endmodule

// File: tb/clk_err_trimmer_tb.sv
module clk_err_trimmer_tb;
    localparam int DIV = 80;
    localparam int SS  = 2;
    localparam int LS  = 3;
    localparam int CW  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b1;
    logic wr_en = 1'b0;
    logic wr_sel = 1'b0;
    logic [CW+1:0] wr_data = '0;
    logic [CW+1:0] trim_reg_o;
    logic short_mode_o, auto_en_o, sec_pulse_o;

    always #10 clk = ~clk;

    clk_err_trimmer #(.PRESC_DIV(DIV), .SHORT_SECS(SS), .LONG_SECS(LS), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .trim_reg_o(trim_reg_o),
        .short_mode_o(short_mode_o), .auto_en_o(auto_en_o),
        .sec_pulse_o(sec_pulse_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit gate_half = 1'b0;

    // bench view of the programmed state
    int cfg_en = 0, cfg_short = 0, cfg_dir = 0, cfg_n = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk)
        osc_tick <= gate_half ? ~osc_tick : 1'b1;

    // second-length monitor with an arithmetic interval model
    int tick_cnt = 0;
    int exp_len = 0;
    int msec = 0;
    bit seen = 1'b0;
    string exp_tag = "R2";
    always @(negedge clk) begin
        if (!rst_n) begin
            tick_cnt = 0; msec = 0; seen = 1'b0;
        end else if (sec_pulse_o) begin
            if (seen) check(exp_tag, tick_cnt, exp_len);
            seen = 1'b1;
            begin
                int ilen;
                bit bnd;
                ilen = cfg_short ? SS : LS;
                bnd = (msec >= ilen - 1);
                exp_len = DIV;
                exp_tag = "R2 R5";
                if (bnd) begin
                    if (!cfg_en && cfg_dir != 0) exp_tag = "R6";
                    else if (cfg_dir == 3) exp_tag = "R8";
                    else if (cfg_dir == 1) begin exp_len = DIV - cfg_n; exp_tag = "R3 R5"; end
                    else if (cfg_dir == 2) begin exp_len = DIV + cfg_n; exp_tag = "R4 R5"; end
                    if (!cfg_en) exp_len = DIV;
                end
                msec = bnd ? 0 : msec + 1;
            end
            tick_cnt = int'(osc_tick);
        end else begin
            tick_cnt = tick_cnt + int'(osc_tick);
        end
    end

    task automatic wait_pulses(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            while (!sec_pulse_o) @(negedge clk);
        end
    endtask

    task automatic wr(input logic sel, input logic [CW+1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input int en, input int sh, input int dir, input int n);
        logic [CW+1:0] adj;
        adj = {2'(dir), 6'(n)};
        wait_pulses(1);
        if (sh != cfg_short) begin
            wr(1'b0, '0); cfg_dir = 0;
        end
        wr(1'b1, {2'b00, 1'(sh), 1'(en), 4'b0000});
        cfg_short = sh; cfg_en = en;
        wr(1'b0, adj);
        cfg_dir = dir; cfg_n = n;
        check("R9", int'(trim_reg_o), int'(adj));
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(trim_reg_o), 0);
        check("R1", int'(short_mode_o), 0);
        check("R1", int'(auto_en_o), 0);
        check("R1", int'(sec_pulse_o), 0);

        wait_pulses(4);
        // R3 and R4 sweeps on the short cadence
        for (int n = 0; n < 64; n++) begin
            set_cfg(1, 1, 1, n);
            wait_pulses(SS + 1);
        end
        for (int n = 0; n < 64; n++) begin
            set_cfg(1, 1, 2, n);
            wait_pulses(SS + 1);
        end
        // long cadence corners
        for (int k = 0; k < 3; k++) begin
            int nn;
            nn = (k == 0) ? 1 : (k == 1) ? 40 : 63;
            set_cfg(1, 0, 1, nn);
            wait_pulses(LS + 1);
            set_cfg(1, 0, 2, nn);
            wait_pulses(LS + 1);
        end
        // R6 disabled, R8 reserved code
        set_cfg(0, 0, 1, 20);
        wait_pulses(LS + 1);
        set_cfg(1, 0, 3, 10);
        wait_pulses(LS + 1);
        // R7 select change refused while direction is non-zero
        set_cfg(1, 0, 2, 7);
        wr(1'b1, 8'b0010_0000);
        check("R7", int'(short_mode_o), 0);
        check("R7", int'(auto_en_o), 0);
        cfg_en = 0;
        wr(1'b1, 8'b0001_0000);
        cfg_en = 1;
        check("R7", int'(auto_en_o), 1);
        wait_pulses(LS + 1);
        wr(1'b0, '0); cfg_dir = 0;
        wr(1'b1, 8'b0011_0000); cfg_short = 1;
        check("R7", int'(short_mode_o), 1);
        // R2 throttled ticks with a correction
        gate_half = 1'b1;
        set_cfg(1, 1, 1, 9);
        wait_pulses(SS + 2);
        set_cfg(1, 1, 2, 9);
        wait_pulses(SS + 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule